// File: doc/BRIEF.md
# Lane Mask and Reconvergence Stack for a SIMT Warp

This block decides which lanes of a warp may commit results while threads follow different sides of a conditional branch. Every lane keeps executing each instruction. A lane whose mask bit is clear has its register-file and memory write requests blocked at this block's output. The branch tests a per-lane negative flag. If the active lanes disagree on that flag, the lanes that take the branch become the new mask. At the same moment, the mask from before the split is saved together with the PC where the two paths meet again.

The saved records sit in a small last-in, first-out stack of parameterised depth. A record is removed in one of two ways. The first is when an issued instruction's PC equals the meeting PC held in the top record; the saved mask is then put back. The second is an explicit synchronise strobe, which removes the top record and hands control to the lanes that sat out the first path. The block also selects the next PC for the warp: the branch target when the warp branches, otherwise the current PC plus one. Two sticky error flags record an attempt to push onto a full stack and an attempt to pop an empty one.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, `active_mask` is all ones, `stack_level` is 0, and both error flags are 0.
- R2: At all times, `lane_wr_en` equals `lane_wr_req` AND `active_mask`, bit for bit (bit i is lane i).
- R3: A branch is uniform when the active lanes with `br_neg` set are either all of the active lanes or none of them. A uniform branch leaves the mask and the stack unchanged. `next_pc` is `br_target` when all active lanes are set and `pc`+1 when none are. Bits of `br_neg` for inactive lanes are ignored.
- R4: A branch is divergent when some, but not all, active lanes have `br_neg` set. If the stack is not full, the block pushes a record holding the current mask and `br_reconv`, `stack_level` rises by 1, the mask becomes `br_neg` AND the old mask on the next clock, and `next_pc` is `br_target` in the same cycle.
- R5: A match occurs when `insn_valid` is 1, the stack is not empty, and `pc` equals the meeting PC of the top record. On a match, the saved mask of that record becomes the mask on the next clock and `stack_level` falls by 1.
- R6: When `sync_valid` is 1 and the stack is not empty, the top record is popped. The new mask is the saved mask AND NOT the current mask; if that result is zero, the saved mask is used instead.
- R7: A divergent branch while `stack_level` equals DEPTH does not push and does not change the mask. `next_pc` is `pc`+1, and `overflow_err` is set and stays set until reset.
- R8: `sync_valid` while the stack is empty sets the mask to all ones and sets `underflow_err`, which stays set until reset.
- R9: Records pop in reverse order of their pushes, so nested splits restore their masks innermost first.
- R10: Only one event acts per cycle, in this order of priority: `br_valid`, then `sync_valid`, then a match. A match needs `insn_valid` to be 1. When `br_valid` is 0, `next_pc` is `pc`+1, wrapping within PC_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Conditional branch issued this cycle |
| br_neg | input | LANES | Per-lane negative flag tested by the branch |
| br_target | input | PC_W | Branch destination |
| br_reconv | input | PC_W | PC where the two paths meet again |
| sync_valid | input | 1 | Explicit synchronise (pop and swap) |
| insn_valid | input | 1 | An instruction at `pc` is issued this cycle |
| pc | input | PC_W | PC of the instruction being issued |
| lane_wr_req | input | LANES | Per-lane write requests from the datapath |
| active_mask | output | LANES | Lanes currently allowed to commit |
| lane_wr_en | output | LANES | Gated write enables |
| next_pc | output | PC_W | PC the warp fetches next |
| stack_level | output | $clog2(DEPTH+1) | Number of records held |
| overflow_err | output | 1 | Sticky: push attempted on a full stack |
| underflow_err | output | 1 | Sticky: pop attempted on an empty stack |

## Verification
The bench builds nested splits and checks that they unwind innermost first. If a design popped from the wrong end, it would restore an outer mask too early, and lanes would write on the wrong path. The bench branches with flags set on inactive lanes; a design that counted those flags would push a spurious record. It fills the stack and then adds one more split; a design without the full guard would overwrite a record or wrap the level. It also raises the branch, synchronise and match events in the same cycle. A design with the wrong priority would either lose the push or restore the full mask where the complementary lanes were expected.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    // Classification of a branch against the lanes that are currently live.
    typedef enum logic [1:0] {
        BRK_NONE    = 2'd0,  // no branch this cycle
        BRK_FALL    = 2'd1,  // every live lane falls through
        BRK_UNIFORM = 2'd2,  // every live lane takes the branch
        BRK_SPLIT   = 2'd3   // live lanes disagree
    } br_kind_t;

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
    import simt_mask_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             br_valid,
    input  logic [LANES-1:0] br_neg,
    input  logic [LANES-1:0] live_mask,
    output logic [LANES-1:0] taken_mask,
    output br_kind_t         kind
);

    logic [LANES-1:0] take_lane;

    // Each lane takes the branch only if it is live and its flag is set.
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign take_lane[gi] = br_neg[gi] & live_mask[gi];
    end

    assign taken_mask = take_lane;

    always_comb begin
        if (!br_valid) begin
            kind = BRK_NONE;
        end else if (take_lane == '0) begin
            kind = BRK_FALL;
        end else if (take_lane == live_mask) begin
            kind = BRK_UNIFORM;
        end else begin
            kind = BRK_SPLIT;
        end
    end

endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack #(
    parameter int LANES = 8,
    parameter int PC_W  = 8,
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic             pop_en,
    input  logic [LANES-1:0] push_mask,
    input  logic [PC_W-1:0]  push_pc,
    output logic [LANES-1:0] top_mask,
    output logic [PC_W-1:0]  top_pc,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  pc;
    } rec_t;

    typedef struct packed {
        rec_t [DEPTH-1:0] rec;
        logic [LVL_W-1:0] lvl;
    } stk_t;

    stk_t st_d, st_q;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    assign wr_idx  = IDX_W'(st_q.lvl);
    assign top_idx = IDX_W'(st_q.lvl - LVL_W'(1));
    assign empty   = (st_q.lvl == '0);
    assign full    = (st_q.lvl == LVL_W'(DEPTH));
    assign level   = st_q.lvl;
    assign top_mask = st_q.rec[top_idx].mask;
    assign top_pc   = st_q.rec[top_idx].pc;

    always_comb begin
        st_d = st_q;
        if (push_en && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    st_d.rec[i].mask = push_mask;
                    st_d.rec[i].pc   = push_pc;
                end
            end
            st_d.lvl = st_q.lvl + LVL_W'(1);
        end else if (pop_en && !empty) begin
            st_d.lvl = st_q.lvl - LVL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PC_W  = 8,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_neg,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             sync_valid,
    input  logic             insn_valid,
    input  logic [PC_W-1:0]  pc,
    input  logic [LANES-1:0] lane_wr_req,
    output logic [LANES-1:0] active_mask,
    output logic [LANES-1:0] lane_wr_en,
    output logic [PC_W-1:0]  next_pc,
    output logic [LVL_W-1:0] stack_level,
    output logic             overflow_err,
    output logic             underflow_err
);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic             ovf;
        logic             unf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LANES-1:0] taken_mask;
    br_kind_t         kind;
    logic [LANES-1:0] top_mask;
    logic [PC_W-1:0]  top_pc;
    logic             stk_empty;
    logic             stk_full;
    logic             push_en;
    logic             sync_pop;
    logic             match_pop;
    logic [LANES-1:0] other_lanes;

    simt_branch_eval #(
        .LANES(LANES)
    ) u_eval (
        .br_valid  (br_valid),
        .br_neg    (br_neg),
        .live_mask (ctl_q.mask),
        .taken_mask(taken_mask),
        .kind      (kind)
    );

    // Event priority: branch, then synchronise, then match on issue.
    assign push_en   = (kind == BRK_SPLIT) && !stk_full;
    assign sync_pop  = !br_valid && sync_valid && !stk_empty;
    assign match_pop = !br_valid && !sync_valid && insn_valid
                       && !stk_empty && (pc == top_pc);

    simt_recon_stack #(
        .LANES(LANES),
        .PC_W (PC_W),
        .DEPTH(DEPTH),
        .LVL_W(LVL_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .pop_en   (sync_pop | match_pop),
        .push_mask(ctl_q.mask),
        .push_pc  (br_reconv),
        .top_mask (top_mask),
        .top_pc   (top_pc),
        .level    (stack_level),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    assign other_lanes = top_mask & ~ctl_q.mask;

    always_comb begin
        ctl_d = ctl_q;
        if (kind == BRK_SPLIT) begin
            if (stk_full) begin
                ctl_d.ovf = 1'b1;
            end else begin
                ctl_d.mask = taken_mask;
            end
        end else if (!br_valid && sync_valid) begin
            if (stk_empty) begin
                ctl_d.unf  = 1'b1;
                ctl_d.mask = '1;
            end else if (other_lanes != '0) begin
                ctl_d.mask = other_lanes;
            end else begin
                ctl_d.mask = top_mask;
            end
        end else if (match_pop) begin
            ctl_d.mask = top_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mask <= '1;
            ctl_q.ovf  <= 1'b0;
            ctl_q.unf  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (kind == BRK_UNIFORM || push_en) begin
            next_pc = br_target;
        end else begin
            next_pc = pc + PC_W'(1);
        end
    end

    assign active_mask   = ctl_q.mask;
    assign lane_wr_en    = lane_wr_req & ctl_q.mask;
    assign overflow_err  = ctl_q.ovf;
    assign underflow_err = ctl_q.unf;

endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
    parameter int LANES = 8,
    parameter int PC_W  = 8,
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic [LANES-1:0] br_neg,
    input logic [PC_W-1:0]  br_target,
    input logic             sync_valid,
    input logic [LANES-1:0] active_mask,
    input logic [LANES-1:0] lane_wr_en,
    input logic [PC_W-1:0]  next_pc,
    input logic [LVL_W-1:0] stack_level,
    input logic             overflow_err,
    input logic             underflow_err
);

    logic [LANES-1:0] live_take;
    logic             split_ev;
    logic             at_cap;

    assign live_take = br_neg & active_mask;
    assign split_ev  = br_valid && (live_take != '0) && (live_take != active_mask);
    assign at_cap    = (stack_level == LVL_W'(DEPTH));

    p_wr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr_en & ~active_mask) == '0);

    p_uniform_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !split_ev) |=> ($stable(active_mask) && $stable(stack_level)));

    p_split_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (split_ev && !at_cap) |=> (stack_level == LVL_W'($past(stack_level) + 1'b1)
                                   && active_mask == $past(live_take)));

    p_split_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (split_ev && !at_cap) |-> (next_pc == br_target));

    p_mask_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (split_ev && at_cap) |=> (overflow_err && $stable(stack_level)
                                  && $stable(active_mask)));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && sync_valid && stack_level == '0) |=>
            (underflow_err && active_mask == '1));

    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stack_level <= LVL_W'(DEPTH));

endmodule

bind simt_mask_stack simt_mask_stack_chk #(
    .LANES(LANES),
    .PC_W (PC_W),
    .DEPTH(DEPTH),
    .LVL_W(LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_valid     (br_valid),
    .br_neg       (br_neg),
    .br_target    (br_target),
    .sync_valid   (sync_valid),
    .active_mask  (active_mask),
    .lane_wr_en   (lane_wr_en),
    .next_pc      (next_pc),
    .stack_level  (stack_level),
    .overflow_err (overflow_err),
    .underflow_err(underflow_err)
);

// File: tb/simt_mask_stack_tb.sv
module simt_mask_stack_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int PC_W  = 8;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_neg = '0;
    logic [PC_W-1:0]  br_target = '0;
    logic [PC_W-1:0]  br_reconv = '0;
    logic             sync_valid = 1'b0;
    logic             insn_valid = 1'b0;
    logic [PC_W-1:0]  pc = '0;
    logic [LANES-1:0] lane_wr_req = '0;
    logic [LANES-1:0] active_mask;
    logic [LANES-1:0] lane_wr_en;
    logic [PC_W-1:0]  next_pc;
    logic [2:0]       stack_level;
    logic             overflow_err;
    logic             underflow_err;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        string            tag;
        logic [LANES-1:0] mask;
        int               lvl;
        bit               ovf;
        bit               unf;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    // Reference model state, maintained from the requirements.
    logic [LANES-1:0] m_mask = '1;
    logic [LANES-1:0] m_smask [DEPTH];
    logic [PC_W-1:0]  m_spc   [DEPTH];
    int               m_lvl = 0;
    bit               m_ovf = 0;
    bit               m_unf = 0;

    simt_mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_neg(br_neg),
        .br_target(br_target), .br_reconv(br_reconv), .sync_valid(sync_valid),
        .insn_valid(insn_valid), .pc(pc), .lane_wr_req(lane_wr_req),
        .active_mask(active_mask), .lane_wr_en(lane_wr_en), .next_pc(next_pc),
        .stack_level(stack_level), .overflow_err(overflow_err),
        .underflow_err(underflow_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares registered state one edge after each driven cycle.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            cur = exp_q.pop_front();
            check({cur.tag, " mask"}, 32'(active_mask), 32'(cur.mask));
            check({cur.tag, " level"}, 32'(stack_level), 32'(cur.lvl));
            check({cur.tag, " ovf"}, 32'(overflow_err), 32'(cur.ovf));
            check({cur.tag, " unf"}, 32'(underflow_err), 32'(cur.unf));
        end
    end

    // Driver: applies one cycle of stimulus, checks combinational outputs,
    // advances the model and queues the state expected after the edge.
    task automatic step(string tag, bit br, logic [LANES-1:0] neg,
                        logic [PC_W-1:0] tgt, logic [PC_W-1:0] rcv, bit sy,
                        bit iv, logic [PC_W-1:0] pcv, logic [LANES-1:0] req);
        logic [LANES-1:0] take;
        logic [LANES-1:0] comp;
        logic [PC_W-1:0]  exp_pc;
        bit               split;
        exp_t             e;
        @(negedge clk);
        br_valid = br; br_neg = neg; br_target = tgt; br_reconv = rcv;
        sync_valid = sy; insn_valid = iv; pc = pcv; lane_wr_req = req;
        #1;
        take   = neg & m_mask;
        split  = br && take != '0 && take != m_mask;
        exp_pc = pcv + 8'd1;
        if (br && take == m_mask) exp_pc = tgt;
        if (split && m_lvl < DEPTH) exp_pc = tgt;
        check({tag, " next_pc"}, 32'(next_pc), 32'(exp_pc));
        check({tag, " R2 wr_en"}, 32'(lane_wr_en), 32'(req & m_mask));
        if (br) begin
            if (split) begin
                if (m_lvl == DEPTH) begin
                    m_ovf = 1;
                end else begin
                    m_smask[m_lvl] = m_mask;
                    m_spc[m_lvl]   = rcv;
                    m_lvl++;
                    m_mask = take;
                end
            end
        end else if (sy) begin
            if (m_lvl == 0) begin
                m_unf  = 1;
                m_mask = '1;
            end else begin
                comp   = m_smask[m_lvl-1] & ~m_mask;
                m_mask = (comp != '0) ? comp : m_smask[m_lvl-1];
                m_lvl--;
            end
        end else if (iv && m_lvl > 0 && pcv == m_spc[m_lvl-1]) begin
            m_mask = m_smask[m_lvl-1];
            m_lvl--;
        end
        e.tag = tag; e.mask = m_mask; e.lvl = m_lvl; e.ovf = m_ovf; e.unf = m_unf;
        exp_q.push_back(e);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog all-reqs actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset mask", 32'(active_mask), 32'hFF);
        check("R1 reset level", 32'(stack_level), 0);
        check("R1 reset ovf", 32'(overflow_err), 0);
        check("R1 reset unf", 32'(underflow_err), 0);

        step("R2 idle gating",        0, 8'h00, 8'h00, 8'h00, 0, 1, 8'h10, 8'hA5);
        step("R3 uniform taken",      1, 8'hFF, 8'h20, 8'h30, 0, 1, 8'h05, 8'h00);
        step("R3 uniform fall",       1, 8'h00, 8'h20, 8'h30, 0, 1, 8'h06, 8'h00);
        step("R4 split",              1, 8'h0F, 8'h40, 8'h50, 0, 1, 8'h08, 8'hFF);
        step("R2 gated after split",  0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h40, 8'hFF);
        step("R3 inactive ignored",   1, 8'h3F, 8'h44, 8'h4C, 0, 1, 8'h41, 8'h00);
        step("R9 nested split",       1, 8'h03, 8'h46, 8'h48, 0, 1, 8'h44, 8'h00);
        step("R5 no match",           0, 8'h00, 8'h00, 8'h00, 0, 1, 8'h47, 8'hFF);
        step("R10 match needs issue", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h48, 8'h00);
        step("R5 match restores",     0, 8'h00, 8'h00, 8'h00, 0, 1, 8'h48, 8'hFF);
        step("R6 sync swaps",         0, 8'h00, 8'h00, 8'h00, 1, 1, 8'h49, 8'hFF);
        step("R8 underflow",          0, 8'h00, 8'h00, 8'h00, 1, 1, 8'h4A, 8'h00);
        step("R10 branch over sync",  1, 8'h01, 8'h58, 8'h60, 1, 1, 8'h4B, 8'h00);
        step("R10 sync over match",   0, 8'h00, 8'h00, 8'h00, 1, 1, 8'h60, 8'hFF);
        step("R7 fill 1",             1, 8'h7E, 8'h70, 8'h81, 0, 1, 8'h61, 8'h00);
        step("R7 fill 2",             1, 8'h3E, 8'h71, 8'h82, 0, 1, 8'h70, 8'h00);
        step("R7 fill 3",             1, 8'h1E, 8'h72, 8'h83, 0, 1, 8'h71, 8'h00);
        step("R7 fill 4",             1, 8'h0E, 8'h73, 8'h84, 0, 1, 8'h72, 8'h00);
        step("R7 overflow",           1, 8'h06, 8'h74, 8'h85, 0, 1, 8'h73, 8'hFF);
        step("R7 sticky",             0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h74, 8'h00);
        step("R9 pop 4",              0, 8'h00, 8'h00, 8'h00, 0, 1, 8'h84, 8'h00);
        step("R9 pop 3",              0, 8'h00, 8'h00, 8'h00, 0, 1, 8'h83, 8'h00);
        step("R9 pop 2",              0, 8'h00, 8'h00, 8'h00, 0, 1, 8'h82, 8'h00);
        step("R9 pop 1",              0, 8'h00, 8'h00, 8'h00, 0, 1, 8'h81, 8'hFF);
        step("R3 wrap fall",          1, 8'h01, 8'h10, 8'h11, 0, 1, 8'hFF, 8'h00);
        step("R10 wrap idle",         0, 8'h00, 8'h00, 8'h00, 0, 1, 8'hFF, 8'hFF);
        step("R1 quiet",              0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00);
        repeat (3) @(posedge clk);
        #2;
        check("R9 queue drained", 32'(exp_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule